// File: doc/BRIEF.md
# PWM Period Timer

This block is one general-purpose timer channel with a pulse-width-modulation output. Software uses a small 32-bit register bus to set a prescale divider, a period length in ticks and a high-time width. Once the channel is switched into PWM mode, it drives a repeating waveform on one output pin. The pin is high from the start of each period until the tick count reaches the active width. It is low for the rest of the period.

The width register is buffered. A value written during a period is copied into the active width only when the next period starts, so the waveform never changes in the middle of a cycle. At each period boundary the channel sets a sticky pending flag and advances a 3-bit wrapping rollover count. The first period after a start is the exception, because it does not begin at a rollover. Software reloads the width in the service routine for that flag. The interrupt line is the pending flag gated by an enable bit in the mode register.

Top module: `pwm_period_timer`

## Requirements
- R1: After reset the pin and the interrupt line are low, and the mode, counter, width and status registers read as zero.
- R2: Registers are decoded at byte offsets 0x10 (mode: select in bits 2:0, interrupt enable in bit 8), 0x14 (counter: prescale in bits 31:16, period in bits 15:0) and 0x18 (width in bits 31:16, bits 15:0 read zero). Written fields read back unchanged.
- R3: In PWM mode (select value 3) a period lasts max(prescale,1) × max(period,1) clock cycles. The first period starts on the second clock edge after the mode write.
- R4: The pin is high for min(width,period) × max(prescale,1) cycles of each period, starting at the period start. A width of 0 keeps the pin low, and a width at or above the period keeps it high.
- R5: A width written during a period has no effect on that period. It takes effect from the next period boundary.
- R6: No rollover event occurs at the start of the first period. Every later period boundary sets the pending flag (status bit 0).
- R7: Writing 1 to status bit 0 clears the pending flag. The interrupt line is high exactly when the pending flag and mode bit 8 are both set.
- R8: Status bits 14:12 count period rollovers modulo 8. The count is cleared while the channel is out of PWM mode.
- R9: Any select value other than 3, including 1xx (plain timer), keeps the pin low, idles the counters and produces no rollovers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Register access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| pwmOut | output | 1 | PWM waveform pin |
| irqOut | output | 1 | Period interrupt request |

## Verification
The hardest case to reach is a width change that arrives mid-period, after the counter has already passed the old width but before it reaches the new one. A design without the buffer would then raise the pin again in that same period. The bench writes a wider value a few ticks into the first period and counts the high cycles of that period and of the next. It also runs enough short periods to wrap the rollover count, and it holds the interrupt enable off while rollovers occur to show that the flag is set but the line stays low.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  parameter int DATA_W = 32;
  parameter int ADDR_W = 8;
  parameter int CNT_W  = 16;
  parameter int SEL_W  = 3;
  parameter int OVF_W  = 3;

  localparam logic [ADDR_W-1:0] MODE_OFS = 8'h10;
  localparam logic [ADDR_W-1:0] CNT_OFS  = 8'h14;
  localparam logic [ADDR_W-1:0] WID_OFS  = 8'h18;
  localparam logic [ADDR_W-1:0] STAT_OFS = 8'h1C;

  localparam logic [SEL_W-1:0] SEL_PWM = 3'd3;
  localparam int IRQ_EN_BIT = 8;
  localparam int OVF_LSB    = 12;

  // configuration and run strobe from control to datapath
  typedef struct packed {
    logic             run;
    logic [CNT_W-1:0] preDiv;
    logic [CNT_W-1:0] perLen;
    logic [CNT_W-1:0] widthNext;
  } pwmCfg_t;
endpackage

// File: rtl/pwm_timer_ctrl.sv
module pwm_timer_ctrl
  import pwm_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              rollover,
  output pwmCfg_t           cfg,
  output logic              pendFlag,
  output logic [OVF_W-1:0]  ovfCnt,
  output logic              irqOut
);
  localparam int HALF_W = DATA_W / 2;

  logic [SEL_W-1:0] modeSel;
  logic             irqEn;
  logic [CNT_W-1:0] preDiv, perLen, widthNext;
  logic             wrHit, runNow;

  assign wrHit  = busSel && busWr;
  assign runNow = (modeSel == SEL_PWM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeSel   <= '0;
      irqEn     <= 1'b0;
      preDiv    <= '0;
      perLen    <= '0;
      widthNext <= '0;
    end else if (wrHit) begin
      case (busAddr)
        MODE_OFS: begin
          modeSel <= busWdata[SEL_W-1:0];
          irqEn   <= busWdata[IRQ_EN_BIT];
        end
        CNT_OFS: begin
          preDiv <= busWdata[DATA_W-1:HALF_W];
          perLen <= busWdata[CNT_W-1:0];
        end
        WID_OFS: widthNext <= busWdata[DATA_W-1:HALF_W];
        default: ;
      endcase
    end
  end

  // sticky pending flag: a rollover wins over a simultaneous clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      pendFlag <= 1'b0;
    else if (rollover)
      pendFlag <= 1'b1;
    else if (wrHit && busAddr == STAT_OFS && busWdata[0])
      pendFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      ovfCnt <= '0;
    else if (!runNow)
      ovfCnt <= '0;
    else if (rollover)
      ovfCnt <= ovfCnt + 1'b1;
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      MODE_OFS: begin
        busRdata[SEL_W-1:0]  = modeSel;
        busRdata[IRQ_EN_BIT] = irqEn;
      end
      CNT_OFS:  busRdata = {preDiv, perLen};
      WID_OFS:  busRdata[DATA_W-1:HALF_W] = widthNext;
      STAT_OFS: begin
        busRdata[OVF_LSB+OVF_W-1:OVF_LSB] = ovfCnt;
        busRdata[0] = pendFlag;
      end
      default: busRdata = '0;
    endcase
  end

  assign cfg.run       = runNow;
  assign cfg.preDiv    = preDiv;
  assign cfg.perLen    = perLen;
  assign cfg.widthNext = widthNext;
  assign irqOut        = pendFlag && irqEn;
endmodule

// File: rtl/pwm_timer_datapath.sv
module pwm_timer_datapath
  import pwm_timer_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  pwmCfg_t cfg,
  output logic    pwmOut,
  output logic    rollover
);
  logic             running;
  logic [CNT_W-1:0] preCnt, tickCnt, activeWidth;
  logic [CNT_W-1:0] preLim, perLim;
  logic             tickEnd, wrapNow;

  // a zero divider or period behaves as one
  assign preLim = (cfg.preDiv == '0) ? CNT_W'(1) : cfg.preDiv;
  assign perLim = (cfg.perLen == '0) ? CNT_W'(1) : cfg.perLen;

  assign tickEnd  = running && (preCnt >= preLim - 1'b1);
  assign wrapNow  = tickEnd && (tickCnt >= perLim - 1'b1);
  assign rollover = wrapNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running     <= 1'b0;
      preCnt      <= '0;
      tickCnt     <= '0;
      activeWidth <= '0;
    end else if (!cfg.run) begin
      running     <= 1'b0;
      preCnt      <= '0;
      tickCnt     <= '0;
      activeWidth <= '0;
    end else if (!running) begin
      // first period opens without a rollover event
      running     <= 1'b1;
      preCnt      <= '0;
      tickCnt     <= '0;
      activeWidth <= cfg.widthNext;
    end else if (tickEnd) begin
      preCnt <= '0;
      if (wrapNow) begin
        tickCnt     <= '0;
        activeWidth <= cfg.widthNext;
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  assign pwmOut = running && (tickCnt < activeWidth);
endmodule

// File: rtl/pwm_period_timer.sv
module pwm_period_timer
  import pwm_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              pwmOut,
  output logic              irqOut
);
  pwmCfg_t          cfg;
  logic             rollover;
  logic             pendFlag;
  logic [OVF_W-1:0] ovfCnt;

  pwm_timer_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .rollover (rollover),
    .cfg      (cfg),
    .pendFlag (pendFlag),
    .ovfCnt   (ovfCnt),
    .irqOut   (irqOut)
  );

  pwm_timer_datapath uDp (
    .clk      (clk),
    .rstN     (rstN),
    .cfg      (cfg),
    .pwmOut   (pwmOut),
    .rollover (rollover)
  );
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk
  import pwm_timer_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             run,
  input logic             rollover,
  input logic             pendFlag,
  input logic [OVF_W-1:0] ovfCnt,
  input logic             pwmOut,
  input logic             irqOut
);
  // R9
  pin_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> !pwmOut);

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> pendFlag);

  // R6
  pend_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    rollover |=> pendFlag);

  // R8
  ovf_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rollover && run) |=> (ovfCnt == $past(ovfCnt) + 1'b1));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !$past(run)) |-> !rollover);
endmodule

bind pwm_period_timer pwm_timer_chk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .run      (cfg.run),
  .rollover (rollover),
  .pendFlag (pendFlag),
  .ovfCnt   (ovfCnt),
  .pwmOut   (pwmOut),
  .irqOut   (irqOut)
);

// File: tb/tb_pwm_period_timer.sv
`timescale 1ns/1ps
module tb_pwm_period_timer;
  localparam logic [7:0] A_MODE = 8'h10;
  localparam logic [7:0] A_CNT  = 8'h14;
  localparam logic [7:0] A_WID  = 8'h18;
  localparam logic [7:0] A_STAT = 8'h1C;
  localparam int VEC_N = 5;
  // {prescale, period, width}
  localparam logic [47:0] VEC [VEC_N] = '{
    {16'd1, 16'd8, 16'd3},
    {16'd2, 16'd5, 16'd2},
    {16'd0, 16'd4, 16'd0},
    {16'd1, 16'd6, 16'd9},
    {16'd3, 16'd4, 16'd4}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [7:0] busAddr = 8'h0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic pwmOut, irqOut;

  int total = 0, bad = 0;
  int pre, per, wid, nCyc, expHi, hi, firstIrq, hi2;
  logic [31:0] rdv;
  logic irqEarly;

  always #2.5 clk = ~clk;

  pwm_period_timer dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pwmOut(pwmOut), .irqOut(irqOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #0.5;
    d = busRdata;
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(pwmOut == 1'b0, "R1 pin", pwmOut, 0);
    check(irqOut == 1'b0, "R1 irq", irqOut, 0);
    rd(A_MODE, rdv); check(rdv == 0, "R1 mode", rdv, 0);
    rd(A_STAT, rdv); check(rdv == 0, "R1 status", rdv, 0);
    rstN = 1'b1;

    // R2: readback
    wr(A_MODE, 32'h0000_0105); rd(A_MODE, rdv);
    check(rdv == 32'h105, "R2 mode", rdv, 32'h105);
    wr(A_CNT, 32'h0003_0007); rd(A_CNT, rdv);
    check(rdv == 32'h0003_0007, "R2 counter", rdv, 32'h0003_0007);
    wr(A_WID, 32'h1234_5678); rd(A_WID, rdv);
    check(rdv == 32'h1234_0000, "R2 width", rdv, 32'h1234_0000);

    // R3 R4 R6 R8: vector table
    for (int v = 0; v < VEC_N; v++) begin
      pre = int'(VEC[v][47:32]); per = int'(VEC[v][31:16]); wid = int'(VEC[v][15:0]);
      if (pre == 0) pre = 1;
      if (per == 0) per = 1;
      nCyc = pre * per;
      expHi = ((wid < per) ? wid : per) * pre;
      wr(A_MODE, 32'h0);
      wr(A_CNT, VEC[v][47:16]);
      wr(A_WID, {VEC[v][15:0], 16'h0});
      wr(A_STAT, 32'h1);
      wr(A_MODE, 32'h103);
      hi = 0; firstIrq = -1;
      for (int n = 2; n <= 2 * nCyc + 2; n++) begin
        @(negedge clk);
        if (irqOut && firstIrq < 0) firstIrq = n;
        if (n >= nCyc + 2 && n <= 2 * nCyc + 1 && pwmOut) hi++;
      end
      check(firstIrq == nCyc + 2, "R3 R6 first interrupt cycle", firstIrq, nCyc + 2);
      check(hi == expHi, "R4 high cycles", hi, expHi);
      rd(A_STAT, rdv);
      check(rdv[14:12] == 3'd2, "R8 rollovers", int'(rdv[14:12]), 2);
    end

    // R5: width shadow, R7 with enable off
    wr(A_MODE, 32'h0);
    wr(A_STAT, 32'h1);
    wr(A_CNT, 32'h0001_000A);
    wr(A_WID, 32'h0002_0000);
    wr(A_MODE, 32'h003);
    hi = 0; hi2 = 0; irqEarly = 1'b0;
    for (int n = 2; n <= 21; n++) begin
      @(negedge clk);
      if (irqOut) irqEarly = 1'b1;
      if (n <= 11 && pwmOut) hi++;
      if (n >= 12 && pwmOut) hi2++;
      if (n == 5) begin
        busSel = 1'b1; busWr = 1'b1; busAddr = A_WID; busWdata = 32'h0007_0000;
      end
      if (n == 6) begin
        busSel = 1'b0; busWr = 1'b0;
      end
    end
    check(hi == 2, "R5 old width kept", hi, 2);
    check(hi2 == 7, "R5 new width applied", hi2, 7);
    check(!irqEarly, "R7 irq masked", irqEarly, 0);
    rd(A_STAT, rdv);
    check(rdv[0] == 1'b1, "R6 pending set", rdv[0], 1);
    wr(A_MODE, 32'h103);
    check(irqOut == 1'b1, "R7 irq on enable", irqOut, 1);
    wr(A_STAT, 32'h1);
    check(irqOut == 1'b0, "R7 cleared", irqOut, 0);
    repeat (6) @(negedge clk);
    check(irqOut == 1'b0, "R7 stays cleared", irqOut, 0);
    @(negedge clk);
    check(irqOut == 1'b1, "R6 next boundary", irqOut, 1);

    // R9: plain timer select
    wr(A_MODE, 32'h104);
    wr(A_STAT, 32'h1);
    hi = 0; irqEarly = 1'b0;
    for (int n = 0; n < 30; n++) begin
      @(negedge clk);
      if (pwmOut) hi++;
      if (irqOut) irqEarly = 1'b1;
    end
    check(hi == 0, "R9 pin idle", hi, 0);
    check(!irqEarly, "R9 no rollover irq", irqEarly, 0);
    rd(A_STAT, rdv);
    check(rdv == 0, "R8 R9 status idle", rdv, 0);

    // R8: wrap of rollover count
    wr(A_CNT, 32'h0001_0002);
    wr(A_MODE, 32'h003);
    for (int n = 2; n <= 20; n++) begin
      @(negedge clk);
      if (n == 16) begin
        rd(A_STAT, rdv);
        check(rdv[14:12] == 3'd7, "R8 count 7", int'(rdv[14:12]), 7);
      end
      if (n == 18) begin
        rd(A_STAT, rdv);
        check(rdv[14:12] == 3'd0, "R8 wrap to 0", int'(rdv[14:12]), 0);
      end
    end
    rd(A_STAT, rdv);
    check(rdv[14:12] == 3'd1, "R8 after wrap", int'(rdv[14:12]), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule